// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Queue

This block turns an asynchronous serial line into bytes. A one-cycle enable that pulses sixteen times per bit period paces it. It finds the start of each character, samples every later bit at its centre, and checks the character against the programmed word length and parity. Each byte is stored together with its own parity, framing and break flags.

In queued mode the bytes wait in a 16-entry first-in first-out store. The data-available, trigger and overrun results appear a fixed three receive-clock enables after the stop bit is sampled. A character-timeout interrupt reports bytes that have been left in the store for too long. In single-byte mode the store holds one byte, and a new byte is visible on the second clock after its stop bit is sampled. The host pops bytes with a read strobe and acknowledges line errors with a status-read strobe.

The configuration inputs and the mode are expected to stay static between resets. The serial input is expected to be synchronised to `clk` already.

Top module: `uart_rx_core`

## Requirements
- R1: Characters are received least significant bit first, with `cfg_len` selecting the data width (00=5, 01=6, 10=7, 11=8 bits). Unused upper bits of `rx_byte` read 0.
- R2: A start is only accepted when the line, first seen low on a `rx_tick`, is still low on the 8th `rx_tick` after that. Otherwise no character is produced.
- R3: When `cfg_par_en` is 1, `st_parity` is set for a byte whose parity bit differs from the expected value. With `cfg_par_even`=1 the expected value is the XOR of the data bits; with `cfg_par_even`=0 it is the inverse of that XOR.
- R4: `st_framing` is set for a byte whose stop bit is sampled low.
- R5: When every data bit, the parity bit (if enabled) and the stop bit are all sampled low, the stored byte is 0x00 with `st_break` and `st_framing` set. The receiver then waits for the line to go high before it accepts a new start.
- R6: In queued mode up to 16 bytes are held and popped in arrival order by `rd_data`. The flags shown always belong to the byte at the head, so they change on the clock after a pop.
- R7: In queued mode a byte enters the store on the third `rx_tick` after its stop-bit sample. In single-byte mode it enters on the clock after the stop-bit sample.
- R8: A character that completes while the store is full (16 bytes in queued mode, 1 in single-byte mode) is dropped and the stored bytes are kept. `st_overrun` is set and stays set until `rd_lsr`.
- R9: In queued mode `irq_data` is high while the fill level is at or above the level that `cfg_trig` selects (00=1, 01=4, 10=8, 11=14). In single-byte mode it follows `rx_avail`.
- R10: `irq_line` is high while an overrun is pending, or while the head byte carries an error flag that `rd_lsr` has not yet acknowledged. `rd_lsr` clears it.
- R11: In queued mode `irq_timeout` rises once the store holds data and no byte has been stored or popped for 64*F+8 `rx_tick`s, where F = 7 + data width offset + parity enable (that is, start, data, parity and one stop bit). A pop clears it.
- R12: `rx_ready` is high whenever `irq_data` or `irq_timeout` is high.
- R13: After reset the store is empty and every status and interrupt output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_tick | input | 1 | Enable at 16 times the bit rate |
| rx_in | input | 1 | Serial input, idle high |
| cfg_len | input | 2 | Data width select |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even (1) or odd (0) parity |
| cfg_fifo_on | input | 1 | Queued mode (1) or single-byte mode (0) |
| cfg_trig | input | 2 | Trigger level select |
| rd_data | input | 1 | Pop the head byte |
| rd_lsr | input | 1 | Status read, acknowledges line errors |
| rx_byte | output | 8 | Head byte, 0 when empty |
| rx_avail | output | 1 | Store not empty |
| st_overrun | output | 1 | Sticky overrun flag |
| st_parity | output | 1 | Head byte parity error |
| st_framing | output | 1 | Head byte framing error |
| st_break | output | 1 | Head byte is a break |
| irq_data | output | 1 | Data-available / trigger interrupt |
| irq_line | output | 1 | Line-error interrupt |
| irq_timeout | output | 1 | Character-timeout interrupt |
| rx_ready | output | 1 | Receive-ready indication |

## Verification
A stop-bit sample taken on a given clock edge registers the finished character on that edge. In single-byte mode the store takes it one edge later. In queued mode the store takes it on the third following `rx_tick` edge, and the timeout fires 64*F+8 ticks after the last store or pop. A behavioural model in the bench keeps its own tick, phase and queue counters and updates them on the same edges from the same inputs. Every output is compared against that model at each falling edge, half a period after the edge, so each deferred result must land in exactly the cycle it is due. Directed checks at the end of each scenario confirm the values the requirements name.

// File: rtl/uart_rx_pkg.sv
// Shared types for the serial receiver: the stored character record and the
// trigger-level decode. Assumes a character never exceeds 8 data bits.
package uart_rx_pkg;

    typedef struct packed {
        logic       brk;
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_char_t;

    // Map the two-bit trigger select to a fill level.
    function automatic logic [4:0] trig_level(input logic [1:0] sel);
        case (sel)
            2'b00:   return 5'd1;
            2'b01:   return 5'd4;
            2'b10:   return 5'd8;
            default: return 5'd14;
        endcase
    endfunction

endpackage

// File: rtl/uart_rx_sampler.sv
// Start detection, mid-bit sampling and character assembly.
// Assumes rxd is synchronised to clk and tick pulses OVS times per bit.
// Emits a one-cycle done pulse, with the finished character, on the clock
// after the stop-bit sample.
module uart_rx_sampler
    import uart_rx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       rxd,
    input  logic [1:0] len_sel,
    input  logic       par_en,
    input  logic       par_even,
    output logic       done,
    output rx_char_t   ch
);
    localparam int PW = $clog2(OVS);
    localparam logic [PW-1:0] PH_MID = PW'(OVS / 2 - 1);
    localparam logic [PW-1:0] PH_END = PW'(OVS - 1);

    typedef enum logic [1:0] {S_IDLE, S_START, S_SHIFT, S_BRKWAIT} st_t;

    st_t           st;
    logic [PW-1:0] ph;
    logic [3:0]    bidx;
    logic [8:0]    shreg;
    logic          all_low;
    logic [3:0]    dlen;
    logic [3:0]    nsmp;
    logic [7:0]    dmask;
    logic [7:0]    dval;
    logic          pbit;
    logic          pexp;

    // Decode the frame shape and check the sampled bits.
    always_comb begin
        dlen  = 4'd5 + {2'b00, len_sel};
        nsmp  = dlen + {3'b000, par_en};
        dmask = 8'hFF >> (4'd8 - dlen);
        dval  = shreg[7:0] & dmask;
        pbit  = shreg[dlen];
        pexp  = par_even ? ^dval : ~^dval;
    end

    // Bit-phase state machine, advanced only on oversampling ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= S_IDLE;
            ph      <= '0;
            bidx    <= '0;
            shreg   <= '0;
            all_low <= 1'b0;
            done    <= 1'b0;
            ch      <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    S_IDLE: begin
                        if (!rxd) begin
                            st <= S_START;
                            ph <= '0;
                        end
                    end
                    S_START: begin
                        if (ph == PH_MID) begin
                            if (rxd) begin
                                st <= S_IDLE;
                            end else begin
                                st      <= S_SHIFT;
                                ph      <= '0;
                                bidx    <= '0;
                                shreg   <= '0;
                                all_low <= 1'b1;
                            end
                        end else begin
                            ph <= ph + 1'b1;
                        end
                    end
                    S_SHIFT: begin
                        if (ph != PH_END) begin
                            ph <= ph + 1'b1;
                        end else begin
                            ph <= '0;
                            if (bidx < nsmp) begin
                                shreg[bidx] <= rxd;
                                all_low     <= all_low & ~rxd;
                                bidx        <= bidx + 1'b1;
                            end else begin
                                done    <= 1'b1;
                                ch.data <= dval;
                                ch.perr <= par_en && (pbit != pexp);
                                ch.ferr <= ~rxd;
                                ch.brk  <= all_low & ~rxd;
                                st      <= (all_low && !rxd) ? S_BRKWAIT : S_IDLE;
                            end
                        end
                    end
                    S_BRKWAIT: begin
                        if (rxd) st <= S_IDLE;
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/uart_rx_fifo.sv
// Circular store of received character records with a fill counter.
// Assumes wr is never raised when full and rd never when empty; the caller
// gates both. The head record is read combinationally.
module uart_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 11
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [W-1:0]               wdata,
    input  logic                       rd,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr) mem[wptr] <= wdata;
    end

    // Pointer and fill-level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (rd) rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            if (wr && !rd)      count <= count + CW'(1);
            else if (rd && !wr) count <= count - CW'(1);
        end
    end

    assign head = mem[rptr];

endmodule

// File: rtl/uart_rx_status.sv
// Commit timing, overrun, error acknowledge, timeout and interrupt logic.
// Assumes configuration is static between resets. In queued mode a finished
// character is held for DLY ticks before it enters the store.
module uart_rx_status
    import uart_rx_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int OVS      = 16,
    parameter int DLY      = 3,
    parameter int TO_CHARS = 4,
    parameter int TO_EXTRA = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       tick,
    input  logic                       done,
    input  rx_char_t                   ch,
    input  logic                       fifo_on,
    input  logic [1:0]                 trig_sel,
    input  logic [1:0]                 len_sel,
    input  logic                       par_en,
    input  logic                       rd_data,
    input  logic                       rd_lsr,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  rx_char_t                   head,
    output logic                       fifo_wr,
    output rx_char_t                   fifo_wdata,
    output logic                       fifo_rd,
    output logic [7:0]                 rx_byte,
    output logic                       rx_avail,
    output logic                       st_overrun,
    output logic                       st_parity,
    output logic                       st_framing,
    output logic                       st_break,
    output logic                       irq_data,
    output logic                       irq_line,
    output logic                       irq_timeout,
    output logic                       rx_ready
);
    localparam int CW  = $clog2(DEPTH + 1);
    localparam int PCW = $clog2(DLY + 1);
    localparam int TOW = $clog2(TO_CHARS * OVS * 12 + TO_EXTRA + 1);

    logic           pend;
    logic [PCW-1:0] pcnt;
    rx_char_t       pch;
    logic           commit;
    logic           full;
    logic           pop;
    logic           ovr;
    logic           ack;
    logic [3:0]     frame;
    logic [TOW-1:0] to_cnt;
    logic [TOW-1:0] to_lim;
    logic           to_hit;
    rx_char_t       hv;

    // Decide when a character enters the store and whether it fits.
    always_comb begin
        pop        = rd_data && (count != '0);
        commit     = fifo_on ? (pend && tick && (pcnt == PCW'(1))) : done;
        fifo_wdata = fifo_on ? pch : ch;
        full       = fifo_on ? (count == CW'(DEPTH)) : (count != '0);
        fifo_wr    = commit && !full;
        fifo_rd    = pop;
        frame      = 4'd7 + {2'b00, len_sel} + {3'b000, par_en};
        to_lim     = TOW'(TO_CHARS * OVS) * TOW'(frame) + TOW'(TO_EXTRA);
        to_hit     = (to_cnt >= to_lim);
    end

    // Hold a finished character for the queued-mode delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
            pcnt <= '0;
            pch  <= '0;
        end else if (done && fifo_on) begin
            pend <= 1'b1;
            pcnt <= PCW'(DLY);
            pch  <= ch;
        end else if (pend && tick) begin
            if (pcnt == PCW'(1)) pend <= 1'b0;
            pcnt <= pcnt - 1'b1;
        end
    end

    // Sticky overrun and head-error acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
            ack <= 1'b0;
        end else begin
            if (commit && full) ovr <= 1'b1;
            else if (rd_lsr)    ovr <= 1'b0;
            if (pop || (fifo_wr && count == '0)) ack <= 1'b0;
            else if (rd_lsr)                     ack <= 1'b1;
        end
    end

    // Count idle ticks while data waits in the store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_cnt <= '0;
        end else if (count == '0 || pop || fifo_wr) begin
            to_cnt <= '0;
        end else if (tick && !to_hit) begin
            to_cnt <= to_cnt + 1'b1;
        end
    end

    // Present head flags and combine interrupts.
    always_comb begin
        rx_avail    = (count != '0);
        hv          = rx_avail ? head : '0;
        rx_byte     = hv.data;
        st_parity   = hv.perr;
        st_framing  = hv.ferr;
        st_break    = hv.brk;
        st_overrun  = ovr;
        irq_line    = ovr | ((hv.perr | hv.ferr | hv.brk) & ~ack);
        irq_data    = fifo_on ? (count >= CW'(trig_level(trig_sel))) : rx_avail;
        irq_timeout = fifo_on && to_hit;
        rx_ready    = irq_data | irq_timeout;
    end

endmodule

// File: rtl/uart_rx_core.sv
// Top of the serial receiver: sampler, character store and status logic.
// Assumes rx_in is already synchronised and configuration is static between
// resets.
module uart_rx_core
    import uart_rx_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int OVS   = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_tick,
    input  logic       rx_in,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_even,
    input  logic       cfg_fifo_on,
    input  logic [1:0] cfg_trig,
    input  logic       rd_data,
    input  logic       rd_lsr,
    output logic [7:0] rx_byte,
    output logic       rx_avail,
    output logic       st_overrun,
    output logic       st_parity,
    output logic       st_framing,
    output logic       st_break,
    output logic       irq_data,
    output logic       irq_line,
    output logic       irq_timeout,
    output logic       rx_ready
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int W  = $bits(rx_char_t);

    logic          done;
    rx_char_t      ch;
    logic          fifo_wr;
    logic          fifo_rd;
    rx_char_t      fifo_wdata;
    logic [W-1:0]  head_raw;
    rx_char_t      head;
    logic [CW-1:0] count;

    assign head = rx_char_t'(head_raw);

    uart_rx_sampler #(.OVS(OVS)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (rx_tick),
        .rxd      (rx_in),
        .len_sel  (cfg_len),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .done     (done),
        .ch       (ch)
    );

    uart_rx_fifo #(.DEPTH(DEPTH), .W(W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fifo_wr),
        .wdata (fifo_wdata),
        .rd    (fifo_rd),
        .head  (head_raw),
        .count (count)
    );

    uart_rx_status #(.DEPTH(DEPTH), .OVS(OVS)) u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (rx_tick),
        .done        (done),
        .ch          (ch),
        .fifo_on     (cfg_fifo_on),
        .trig_sel    (cfg_trig),
        .len_sel     (cfg_len),
        .par_en      (cfg_par_en),
        .rd_data     (rd_data),
        .rd_lsr      (rd_lsr),
        .count       (count),
        .head        (head),
        .fifo_wr     (fifo_wr),
        .fifo_wdata  (fifo_wdata),
        .fifo_rd     (fifo_rd),
        .rx_byte     (rx_byte),
        .rx_avail    (rx_avail),
        .st_overrun  (st_overrun),
        .st_parity   (st_parity),
        .st_framing  (st_framing),
        .st_break    (st_break),
        .irq_data    (irq_data),
        .irq_line    (irq_line),
        .irq_timeout (irq_timeout),
        .rx_ready    (rx_ready)
    );

endmodule

// File: rtl/uart_rx_core_props.sv
// Temporal checks on the receiver ports, attached to every uart_rx_core.
module uart_rx_core_props (
    input logic clk,
    input logic rst_n,
    input logic cfg_fifo_on,
    input logic rd_data,
    input logic rd_lsr,
    input logic rx_avail,
    input logic st_overrun,
    input logic st_parity,
    input logic st_framing,
    input logic st_break,
    input logic irq_data,
    input logic irq_line,
    input logic irq_timeout
);
    // R13: reset empties the store and clears flags
    a_r13_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (!rx_avail && !st_overrun && !irq_line && !irq_timeout));

    // R8: overrun holds until a status read
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_overrun && !rd_lsr) |=> st_overrun);

    // R6: the store only empties through a pop
    a_r6_empty_by_pop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_avail) |-> $past(rd_data));

    // R6: head flags exist only with a head byte
    a_r6_flags_need_data: assert property (@(posedge clk) disable iff (!rst_n)
        (st_parity || st_framing || st_break) |-> rx_avail);

    // R9: data interrupt needs stored data
    a_r9_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        irq_data |-> rx_avail);

    // R11: timeout only in queued mode with data waiting
    a_r11_timeout_scope: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timeout |-> (cfg_fifo_on && rx_avail));

    // R10: line interrupt has a cause
    a_r10_line_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq_line |-> (st_overrun || st_parity || st_framing || st_break));

endmodule

bind uart_rx_core uart_rx_core_props u_props (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_fifo_on (cfg_fifo_on),
    .rd_data     (rd_data),
    .rd_lsr      (rd_lsr),
    .rx_avail    (rx_avail),
    .st_overrun  (st_overrun),
    .st_parity   (st_parity),
    .st_framing  (st_framing),
    .st_break    (st_break),
    .irq_data    (irq_data),
    .irq_line    (irq_line),
    .irq_timeout (irq_timeout)
);

// File: tb/uart_rx_core_test.sv
module uart_rx_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_tick = 1'b0;
    logic       rx_in = 1'b1;
    logic [1:0] cfg_len = 2'b11;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_fifo_on = 1'b0;
    logic [1:0] cfg_trig = 2'b00;
    logic       rd_data = 1'b0;
    logic       rd_lsr = 1'b0;
    logic [7:0] rx_byte;
    logic       rx_avail, st_overrun, st_parity, st_framing, st_break;
    logic       irq_data, irq_line, irq_timeout, rx_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int tcnt = 0;
    bit cmp_on = 1'b0;

    uart_rx_core uut (.*);

    always #10 clk = ~clk;

    // free-running 16x tick, one clock in four
    always @(negedge clk) begin
        tcnt = (tcnt + 1) % 4;
        rx_tick = (tcnt == 0);
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // ---------------- behavioural reference ----------------
    logic [10:0] m_q[$];
    int          ms, mt, mn, pend, mto;
    bit          nfp, movr, mack;
    logic [10:0] pch, nfch;
    logic [8:0]  msmp;

    function automatic int dwidth();
        return 5 + int'(cfg_len);
    endfunction
    function automatic int to_limit();
        return 64 * (2 + dwidth() + int'(cfg_par_en)) + 8;
    endfunction
    function automatic int lvl();
        case (cfg_trig)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            ms = 0; mt = 0; mn = 0; pend = 0; mto = 0;
            nfp = 0; movr = 0; mack = 0;
        end else begin
            bit commit, pop, wrok, wasempty, allz;
            logic [10:0] cch;
            logic [7:0] d;
            int dl, np;
            commit = 0;
            cch = '0;
            pop = rd_data && m_q.size() > 0;
            if (nfp) begin commit = 1; cch = nfch; nfp = 0; end
            if (rx_tick && pend > 0) begin
                if (pend == 1) begin commit = 1; cch = pch; end
                pend--;
            end
            wasempty = (m_q.size() == 0);
            wrok = commit && (m_q.size() < (cfg_fifo_on ? 16 : 1));
            if (wasempty || pop || wrok) mto = 0;
            else if (rx_tick && mto < to_limit()) mto++;
            if (pop || (wrok && wasempty)) mack = 0;
            else if (rd_lsr) mack = 1;
            if (commit && !wrok) movr = 1;
            else if (rd_lsr) movr = 0;
            if (pop) void'(m_q.pop_front());
            if (wrok) m_q.push_back(cch);
            dl = dwidth();
            np = dl + int'(cfg_par_en);
            if (rx_tick) begin
                case (ms)
                    0: if (!rx_in) begin ms = 1; mt = 0; end
                    1: begin
                        mt++;
                        if (mt == 8) begin
                            if (rx_in) ms = 0; else mn = 0;
                        end else if (mt > 8 && (mt - 8) % 16 == 0) begin
                            if (mn < np) begin
                                msmp[mn] = rx_in;
                                mn++;
                            end else begin
                                d = '0;
                                allz = !rx_in;
                                for (int i = 0; i < np; i++) if (msmp[i]) allz = 0;
                                for (int i = 0; i < dl; i++) d[i] = msmp[i];
                                cch = {allz, !rx_in,
                                       cfg_par_en && (msmp[dl] != (cfg_par_even ? ^d : ~^d)), d};
                                if (cfg_fifo_on) begin pend = 3; pch = cch; end
                                else begin nfp = 1; nfch = cch; end
                                ms = allz ? 2 : 0;
                            end
                        end
                    end
                    default: if (rx_in) ms = 0;
                endcase
            end
        end
    end

    // compare every output half a period after the edge
    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            logic [10:0] h;
            bit av, dirq, tirq;
            av = m_q.size() > 0;
            h = av ? m_q[0] : '0;
            dirq = cfg_fifo_on ? (m_q.size() >= lvl()) : av;
            tirq = cfg_fifo_on && (mto >= to_limit());
            check("R1 rx_byte", rx_byte, h[7:0]);
            check("R7 rx_avail", rx_avail, av);
            check("R3 st_parity", st_parity, h[8]);
            check("R4 st_framing", st_framing, h[9]);
            check("R5 st_break", st_break, h[10]);
            check("R8 st_overrun", st_overrun, movr);
            check("R9 irq_data", irq_data, dirq);
            check("R10 irq_line", irq_line, movr | ((h[8] | h[9] | h[10]) & !mack));
            check("R11 irq_timeout", irq_timeout, tirq);
            check("R12 rx_ready", rx_ready, dirq | tirq);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input bit fifo, input logic [1:0] len, input bit pen,
                            input bit peven, input logic [1:0] trig);
        @(negedge clk);
        rst_n = 0; rx_in = 1; rd_data = 0; rd_lsr = 0;
        cfg_fifo_on = fifo; cfg_len = len; cfg_par_en = pen;
        cfg_par_even = peven; cfg_trig = trig;
        wait_clk(3);
        rst_n = 1;
        wait_clk(2);
    endtask

    task automatic send(input logic [7:0] v, input int nb, input int pm,
                        input bit badp, input bit stopv);
        logic p;
        p = 0;
        for (int i = 0; i < nb; i++) p ^= v[i];
        if (pm == 2) p = ~p;
        if (badp) p = ~p;
        rx_in = 0; wait_clk(64);
        for (int i = 0; i < nb; i++) begin rx_in = v[i]; wait_clk(64); end
        if (pm != 0) begin rx_in = p; wait_clk(64); end
        rx_in = stopv;
        wait_clk(stopv ? 64 : 40);
        rx_in = 1;
        wait_clk(80);
    endtask

    task automatic pop_check(input string tag, input int exp);
        check(tag, rx_byte, exp);
        rd_data = 1; wait_clk(1); rd_data = 0;
    endtask

    task automatic lsr_read();
        rd_lsr = 1; wait_clk(1); rd_lsr = 0;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R13 reset state
        do_reset(0, 2'b11, 0, 0, 2'b00);
        cmp_on = 1;
        check("R13 avail", rx_avail, 0);
        check("R13 irq", {irq_data, irq_line, irq_timeout, rx_ready, st_overrun}, 0);

        // R1 / R7 single-byte mode 8N1
        send(8'hA5, 8, 0, 0, 1);
        check("R7 avail after char", rx_avail, 1);
        pop_check("R1 byte A5", 8'hA5);

        // R2 short low pulse is not a start
        rx_in = 0; wait_clk(8); rx_in = 1; wait_clk(1000);
        check("R2 no char from glitch", rx_avail, 0);

        // R3 5-bit even parity
        do_reset(0, 2'b00, 1, 1, 2'b00);
        send(8'h13, 5, 1, 0, 1);
        check("R3 good even parity", st_parity, 0);
        pop_check("R1 5-bit byte", 8'h13);
        send(8'h13, 5, 1, 1, 1);
        check("R3 bad even parity", st_parity, 1);
        check("R10 line irq on error", irq_line, 1);
        lsr_read();
        check("R10 lsr acknowledges", irq_line, 0);
        pop_check("R1 5-bit byte again", 8'h13);

        // R3 7-bit odd parity
        do_reset(0, 2'b10, 1, 0, 2'b00);
        send(8'h41, 7, 2, 0, 1);
        check("R3 good odd parity", st_parity, 0);
        pop_check("R1 7-bit byte", 8'h41);

        // R4 framing error
        do_reset(0, 2'b11, 0, 0, 2'b00);
        send(8'h55, 8, 0, 0, 0);
        check("R4 framing flag", st_framing, 1);
        check("R5 no break on framing", st_break, 0);
        pop_check("R4 framed byte", 8'h55);

        // R5 break
        rx_in = 0; wait_clk(64 * 12); rx_in = 1; wait_clk(200);
        check("R5 break flag", st_break, 1);
        check("R5 break framing", st_framing, 1);
        pop_check("R5 break byte", 8'h00);
        wait_clk(200);
        check("R5 single break entry", rx_avail, 0);

        // R8 overrun in single-byte mode
        send(8'h11, 8, 0, 0, 1);
        send(8'h22, 8, 0, 0, 1);
        check("R8 overrun set", st_overrun, 1);
        check("R8 first byte kept", rx_byte, 8'h11);
        lsr_read();
        check("R8 overrun cleared", st_overrun, 0);
        pop_check("R8 kept byte", 8'h11);

        // R9 / R6 / R12 trigger at 4
        do_reset(1, 2'b11, 0, 0, 2'b01);
        for (int i = 1; i <= 3; i++) send(8'(i), 8, 0, 0, 1);
        check("R9 below trigger", irq_data, 0);
        send(8'h04, 8, 0, 0, 1);
        check("R9 at trigger", irq_data, 1);
        check("R12 ready at trigger", rx_ready, 1);
        for (int i = 1; i <= 4; i++) pop_check("R6 order", i);

        // R8 queued overrun
        do_reset(1, 2'b11, 0, 0, 2'b11);
        for (int i = 0; i < 17; i++) send(8'(8'h30 + i), 8, 0, 0, 1);
        check("R8 queued overrun", st_overrun, 1);
        for (int i = 0; i < 16; i++) pop_check("R6 queued order", 8'h30 + i);
        check("R8 extra dropped", rx_avail, 0);

        // R6 flags follow head after pop, 8E1
        do_reset(1, 2'b11, 1, 1, 2'b11);
        send(8'h01, 8, 1, 0, 1);
        send(8'h02, 8, 1, 1, 1);
        send(8'h03, 8, 1, 0, 1);
        check("R6 head clean", st_parity, 0);
        pop_check("R6 first", 8'h01);
        check("R6 flag after pop", st_parity, 1);
        pop_check("R6 second", 8'h02);
        check("R6 flag cleared after pop", st_parity, 0);
        pop_check("R6 third", 8'h03);

        // R11 / R12 timeout
        do_reset(1, 2'b11, 0, 0, 2'b11);
        send(8'h77, 8, 0, 0, 1);
        check("R11 no early timeout", irq_timeout, 0);
        wait_clk(2700);
        check("R11 timeout raised", irq_timeout, 1);
        check("R12 ready on timeout", rx_ready, 1);
        pop_check("R11 timeout byte", 8'h77);
        check("R11 timeout cleared", irq_timeout, 0);

        wait_clk(20);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule